// File: doc/BRIEF.md
# SD SPI Data-Phase Engine

This block runs the data phase of a memory-card transaction in SPI mode, once the command has been issued and accepted elsewhere. It works one byte at a time through a byte-wide SPI shifter: it asks for an exchange with `spi_go` and the byte in `spi_tx`. The shifter answers with `spi_done` and the received byte in `spi_rx`. The engine handles one block per start, from 1 up to `MAX_LEN` bytes. CRC is neither generated nor checked: zero checksum bytes go out, and the checksum bytes that come in are dropped.

There are three modes. A block read polls for the start token and streams the payload bytes out as they arrive. A block write sends the token, pulls the payload from a ready/valid source, checks the card's data-response nibble and then polls through the card's busy period. A register read fetches a 16-byte card register and presents it as four 32-bit words, last word first. Every transfer ends with a one-cycle `done` pulse that carries a status code.

Top module: `sdx_data_engine`

## Requirements
- R1: While reset is held and right after it is released, `busy`, `done`, `spi_go`, `wr_ready`, `rd_valid` and `word_valid` are all low.
- R2: Only one shifter exchange is outstanding at a time. A new `spi_go` is raised only after `spi_done` has answered the previous one.
- R3: In read and register-read modes (mode 00 and 10) the engine sends 0xFF bytes until it receives a byte other than 0xFF. If it has sent `TOKEN_TRIES` bytes and every reply was 0xFF, it finishes with status 01 (timeout). A 0xFE that arrives on the final try is still accepted.
- R4: If the first byte that is not 0xFF is anything other than 0xFE, the transfer finishes with status 10 (I/O error) and no payload is presented.
- R5: In read mode each payload byte appears on `rd_data` with a one-cycle `rd_valid` in the cycle its `spi_done` arrives, in arrival order, `len` bytes in all. Two more 0xFF exchanges follow and their replies are discarded. The transfer then finishes with status 00.
- R6: In write mode (mode 01) the bytes sent are 0xFE, then the `len` payload bytes taken from `wr_data` on each `wr_valid && wr_ready` handshake, then 0x00, 0x00, then 0xFF. Payload bytes are sent in the order they are accepted.
- R7: The reply to that final 0xFF is the data response. If its low four bits are 0101 the write goes on. Any other value ends the transfer with status 10.
- R8: After an accepted response the engine sends 0xFF bytes until a reply of 0xFF arrives, and then finishes with status 00. If `BUSY_TRIES` polls all come back with other values, it finishes with status 01.
- R9: In register-read mode the engine receives 16 bytes after the token, followed by two discarded checksum bytes. It then raises `word_valid` for four consecutive cycles. The words come out last-received first, and each word is big-endian (its first-received byte in bits 31:24). `rd_valid` stays low throughout.
- R10: `done` is a single-cycle pulse with `busy` high. `busy` is high from the cycle after an accepted start through the `done` cycle, and low in the cycle after `done`.
- R11: `start` has no effect while `busy` is high, and none when mode is 11.
- R12: A payload of `MAX_LEN` (512) bytes is transferred in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (sampled while idle) |
| mode | input | 2 | 00 read, 01 write, 10 register read, 11 none |
| len | input | LEN_W | Payload length in bytes for read and write |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| status | output | 2 | 00 ok, 01 timeout, 10 I/O error; valid with done |
| spi_go | output | 1 | Request one byte exchange |
| spi_tx | output | 8 | Byte to send, valid with spi_go |
| spi_done | input | 1 | Exchange finished |
| spi_rx | input | 8 | Byte received, valid with spi_done |
| wr_data | input | 8 | Write payload byte |
| wr_valid | input | 1 | Write payload byte available |
| wr_ready | output | 1 | Engine takes wr_data this cycle |
| rd_valid | output | 1 | Read payload byte valid |
| rd_data | output | 8 | Read payload byte |
| word_valid | output | 1 | Register word valid |
| word_data | output | 32 | Register word |

## Verification
The bench builds the engine with `TOKEN_TRIES` = 8 and `BUSY_TRIES` = 6, and keeps `MAX_LEN` at 512. These small limits make both timeout paths reachable in a few dozen cycles, including the token that arrives on exactly the last permitted try. The full 512-byte read still runs at the real maximum length. A shifter model with a two-cycle exchange latency and a write source that withholds `wr_valid` every third cycle exercise both the one-exchange-at-a-time rule and handshake stalls in the middle of the payload.

// File: rtl/sdx_pkg.sv
package sdx_pkg;

  typedef enum logic [1:0] {
    MODE_READ  = 2'b00,
    MODE_WRITE = 2'b01,
    MODE_REGRD = 2'b10,
    MODE_NONE  = 2'b11
  } sdx_mode_e;

  typedef enum logic [1:0] {
    ST_OK      = 2'b00,
    ST_TIMEOUT = 2'b01,
    ST_IOERR   = 2'b10
  } sdx_status_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_TOKW,
    S_RDAT,
    S_RCRC,
    S_WTOK,
    S_WDAT,
    S_WCRC,
    S_WRSP,
    S_WBSY,
    S_WOUT,
    S_FIN
  } sdx_state_e;

  localparam logic [7:0] FILL_BYTE   = 8'hFF;
  localparam logic [7:0] START_TOKEN = 8'hFE;
  localparam logic [7:0] PAD_BYTE    = 8'h00;
  localparam logic [3:0] RESP_ACCEPT = 4'b0101;
  localparam int         CRC_BYTES   = 2;

  function automatic logic is_fill(input logic [7:0] b);
    return b == FILL_BYTE;
  endfunction

  function automatic logic resp_accepted(input logic [7:0] b);
    return b[3:0] == RESP_ACCEPT;
  endfunction

  // true when the item numbered cnt (from zero) is the last of limit items
  function automatic logic at_last(input logic [31:0] cnt, input logic [31:0] limit);
    return (cnt + 32'd1) >= limit;
  endfunction

endpackage

// File: rtl/sdx_cnt.sv
module sdx_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else if (inc) q <= q + W'(1);
  end
endmodule

// File: rtl/sdx_word_rev.sv
module sdx_word_rev #(
  parameter int WORDS      = 4,
  parameter int WORD_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [7:0]              byte_in,
  input  logic                    shift,
  output logic [WORD_BYTES*8-1:0] word_out
);
  localparam int WBITS = WORD_BYTES * 8;
  localparam int BITS  = WORDS * WBITS;

  logic [BITS-1:0] buf_q;

  // bytes enter at the bottom, so the last-received word sits lowest
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     buf_q <= '0;
    else if (load)  buf_q <= {buf_q[BITS-9:0], byte_in};
    else if (shift) buf_q <= buf_q >> WBITS;
  end

  assign word_out = buf_q[WBITS-1:0];
endmodule

// File: rtl/sdx_data_engine.sv
module sdx_data_engine
  import sdx_pkg::*;
#(
  parameter int MAX_LEN     = 512,
  parameter int TOKEN_TRIES = 20000,
  parameter int BUSY_TRIES  = 1000000,
  parameter int REG_WORDS   = 4,
  parameter int WORD_BYTES  = 4,
  localparam int LEN_W      = $clog2(MAX_LEN + 1),
  localparam int WBITS      = WORD_BYTES * 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       mode,
  input  logic [LEN_W-1:0] len,
  output logic             busy,
  output logic             done,
  output logic [1:0]       status,
  output logic             spi_go,
  output logic [7:0]       spi_tx,
  input  logic             spi_done,
  input  logic [7:0]       spi_rx,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             word_valid,
  output logic [WBITS-1:0] word_data
);
  localparam int REG_BYTES = REG_WORDS * WORD_BYTES;
  localparam int BC_MAX    = (MAX_LEN > REG_BYTES) ? MAX_LEN : REG_BYTES;
  localparam int BC_W      = $clog2(BC_MAX + 1);
  localparam int TRY_MAX   = (TOKEN_TRIES > BUSY_TRIES) ? TOKEN_TRIES : BUSY_TRIES;
  localparam int TRY_W     = $clog2(TRY_MAX + 1);

  sdx_state_e       state_q, state_d;
  sdx_mode_e        mode_q;
  logic [LEN_W-1:0] len_q;
  sdx_status_e      status_q, status_d;
  logic             pend_q;

  logic [BC_W-1:0]  bc;
  logic [TRY_W-1:0] tc;
  logic             bc_clr, bc_inc, tc_clr, tc_inc;
  logic [BC_W-1:0]  eff_len;
  logic             bc_last;
  logic             need_byte;
  logic             accept;

  // named events for the checker
  logic ev_token_bad;
  logic ev_resp_reject;
  logic ev_accept;

  sdx_cnt #(.W(BC_W)) u_byte_cnt (
    .clk(clk), .rst_n(rst_n), .clr(bc_clr), .inc(bc_inc), .q(bc)
  );

  sdx_cnt #(.W(TRY_W)) u_try_cnt (
    .clk(clk), .rst_n(rst_n), .clr(tc_clr), .inc(tc_inc), .q(tc)
  );

  sdx_word_rev #(.WORDS(REG_WORDS), .WORD_BYTES(WORD_BYTES)) u_word_rev (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept && state_q == S_RDAT && mode_q == MODE_REGRD),
    .byte_in  (spi_rx),
    .shift    (state_q == S_WOUT),
    .word_out (word_data)
  );

  assign accept    = spi_done && pend_q;
  assign ev_accept = accept;
  assign eff_len   = (mode_q == MODE_REGRD) ? BC_W'(REG_BYTES) : BC_W'(len_q);
  assign bc_last   = at_last(32'(bc), 32'(eff_len));

  always_comb begin
    need_byte = 1'b0;
    spi_tx    = FILL_BYTE;
    unique case (state_q)
      S_TOKW, S_RDAT, S_RCRC, S_WRSP, S_WBSY: need_byte = 1'b1;
      S_WTOK: begin need_byte = 1'b1; spi_tx = START_TOKEN; end
      S_WDAT: begin need_byte = wr_valid; spi_tx = wr_data; end
      S_WCRC: begin need_byte = 1'b1; spi_tx = PAD_BYTE; end
      default: ;
    endcase
  end

  assign spi_go   = need_byte && !pend_q;
  assign wr_ready = (state_q == S_WDAT) && !pend_q;

  always_comb begin
    state_d        = state_q;
    status_d       = status_q;
    bc_clr         = 1'b0;
    bc_inc         = 1'b0;
    tc_clr         = 1'b0;
    tc_inc         = 1'b0;
    ev_token_bad   = 1'b0;
    ev_resp_reject = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (start && sdx_mode_e'(mode) != MODE_NONE) begin
          bc_clr  = 1'b1;
          tc_clr  = 1'b1;
          state_d = (sdx_mode_e'(mode) == MODE_WRITE) ? S_WTOK : S_TOKW;
        end
      end
      S_TOKW: if (accept) begin
        if (is_fill(spi_rx)) begin
          if (at_last(32'(tc), 32'(TOKEN_TRIES))) begin
            status_d = ST_TIMEOUT;
            state_d  = S_FIN;
          end else begin
            tc_inc = 1'b1;
          end
        end else if (spi_rx == START_TOKEN) begin
          bc_clr  = 1'b1;
          state_d = (eff_len == '0) ? S_RCRC : S_RDAT;
        end else begin
          ev_token_bad = 1'b1;
          status_d     = ST_IOERR;
          state_d      = S_FIN;
        end
      end
      S_RDAT: if (accept) begin
        if (bc_last) begin bc_clr = 1'b1; state_d = S_RCRC; end
        else bc_inc = 1'b1;
      end
      S_RCRC: if (accept) begin
        if (at_last(32'(bc), 32'(CRC_BYTES))) begin
          bc_clr = 1'b1;
          if (mode_q == MODE_REGRD) state_d = S_WOUT;
          else begin status_d = ST_OK; state_d = S_FIN; end
        end else bc_inc = 1'b1;
      end
      S_WTOK: if (accept) begin
        bc_clr  = 1'b1;
        state_d = (len_q == '0) ? S_WCRC : S_WDAT;
      end
      S_WDAT: if (accept) begin
        if (bc_last) begin bc_clr = 1'b1; state_d = S_WCRC; end
        else bc_inc = 1'b1;
      end
      S_WCRC: if (accept) begin
        if (at_last(32'(bc), 32'(CRC_BYTES))) state_d = S_WRSP;
        else bc_inc = 1'b1;
      end
      S_WRSP: if (accept) begin
        if (resp_accepted(spi_rx)) begin
          tc_clr  = 1'b1;
          state_d = S_WBSY;
        end else begin
          ev_resp_reject = 1'b1;
          status_d       = ST_IOERR;
          state_d        = S_FIN;
        end
      end
      S_WBSY: if (accept) begin
        if (is_fill(spi_rx)) begin
          status_d = ST_OK;
          state_d  = S_FIN;
        end else if (at_last(32'(tc), 32'(BUSY_TRIES))) begin
          status_d = ST_TIMEOUT;
          state_d  = S_FIN;
        end else tc_inc = 1'b1;
      end
      S_WOUT: begin
        if (at_last(32'(bc), 32'(REG_WORDS))) begin
          status_d = ST_OK;
          state_d  = S_FIN;
        end else bc_inc = 1'b1;
      end
      S_FIN:   state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      mode_q   <= MODE_READ;
      len_q    <= '0;
      status_q <= ST_OK;
      pend_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      status_q <= status_d;
      if (state_q == S_IDLE && start) begin
        mode_q <= sdx_mode_e'(mode);
        len_q  <= len;
      end
      if (spi_go)        pend_q <= 1'b1;
      else if (spi_done) pend_q <= 1'b0;
    end
  end

  assign busy       = state_q != S_IDLE;
  assign done       = state_q == S_FIN;
  assign status     = status_q;
  assign rd_valid   = (state_q == S_RDAT) && accept && (mode_q == MODE_READ);
  assign rd_data    = spi_rx;
  assign word_valid = state_q == S_WOUT;

endmodule

// File: rtl/sdx_data_engine_chk.sv
module sdx_data_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic [1:0] status,
  input logic       spi_go,
  input logic [7:0] spi_tx,
  input logic       spi_done,
  input logic [7:0] spi_rx,
  input logic [7:0] wr_data,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic       rd_valid,
  input logic [7:0] rd_data,
  input logic       word_valid,
  input logic       ev_token_bad,
  input logic       ev_resp_reject
);
  logic outstanding_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        outstanding_q <= 1'b0;
    else if (spi_go)   outstanding_q <= 1'b1;
    else if (spi_done) outstanding_q <= 1'b0;
  end

  // R2
  single_exchange_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_go |-> !outstanding_q);

  // R6
  wr_byte_sent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |-> (spi_go && spi_tx == wr_data));

  // R10
  done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy ##1 !busy);

  // R5
  rd_from_shifter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (spi_done && rd_data == spi_rx));

  // R9
  word_not_with_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(word_valid && rd_valid));

  // R4
  bad_token_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_token_bad |=> (done && status == 2'b10));

  // R7
  resp_reject_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_resp_reject |=> (done && status == 2'b10));

  // R10
  status_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> status != 2'b11);
endmodule

bind sdx_data_engine sdx_data_engine_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .busy          (busy),
  .done          (done),
  .status        (status),
  .spi_go        (spi_go),
  .spi_tx        (spi_tx),
  .spi_done      (spi_done),
  .spi_rx        (spi_rx),
  .wr_data       (wr_data),
  .wr_valid      (wr_valid),
  .wr_ready      (wr_ready),
  .rd_valid      (rd_valid),
  .rd_data       (rd_data),
  .word_valid    (word_valid),
  .ev_token_bad  (ev_token_bad),
  .ev_resp_reject(ev_resp_reject)
);

// File: tb/sdx_data_engine_tb.sv
module sdx_data_engine_tb;
  localparam int MAX_LEN = 512;
  localparam int TOK     = 8;
  localparam int BSY     = 6;
  localparam int LAT     = 2;
  localparam int LEN_W   = $clog2(MAX_LEN + 1);

  logic clk = 1'b0;
  logic rst_n;
  logic start;
  logic [1:0] mode;
  logic [LEN_W-1:0] len;
  logic busy, done;
  logic [1:0] status;
  logic spi_go;
  logic [7:0] spi_tx;
  logic spi_done;
  logic [7:0] spi_rx;
  logic [7:0] wr_data;
  logic wr_valid, wr_ready;
  logic rd_valid;
  logic [7:0] rd_data;
  logic word_valid;
  logic [31:0] word_data;

  always #2.5 clk = ~clk;

  sdx_data_engine #(
    .MAX_LEN(MAX_LEN), .TOKEN_TRIES(TOK), .BUSY_TRIES(BSY)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .len(len),
    .busy(busy), .done(done), .status(status),
    .spi_go(spi_go), .spi_tx(spi_tx), .spi_done(spi_done), .spi_rx(spi_rx),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .word_valid(word_valid), .word_data(word_data)
  );

  int checks = 0;
  int errors = 0;
  int done_seen = 0;
  logic [7:0]  rx_q[$];
  logic [7:0]  tx_exp[$];
  logic [7:0]  rd_exp[$];
  logic [31:0] word_exp[$];
  logic [7:0]  wr_pay[$];
  int          wr_idx = 0;
  logic [7:0]  rx_default = 8'hFF;
  logic [1:0]  exp_status = 2'b00;
  string       tx_req = "R3";
  string       st_req = "R5";

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // shifter model and write source
  initial begin
    int cd = 0;
    int cyc = 0;
    spi_done = 1'b0; spi_rx = 8'h00; wr_valid = 1'b0; wr_data = 8'h00;
    forever begin
      @(negedge clk);
      cyc++;
      spi_done = 1'b0;
      if (cd > 0) begin
        cd--;
        if (cd == 0) begin
          spi_done = 1'b1;
          spi_rx = (rx_q.size() > 0) ? rx_q.pop_front() : rx_default;
        end
      end
      wr_valid = (wr_idx < wr_pay.size()) && (cyc % 3 != 0);
      wr_data  = wr_valid ? wr_pay[wr_idx] : 8'h00;
      #1;
      if (wr_valid && wr_ready) wr_idx++;
      if (spi_go && rst_n) begin
        if (tx_exp.size() == 0) chk(1'b0, "R2", "unexpected exchange", spi_tx, 0);
        else begin
          logic [7:0] e;
          e = tx_exp.pop_front();
          chk(spi_tx == e, tx_req, "sent byte", spi_tx, e);
        end
        cd = LAT;
      end
    end
  end

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n && rd_valid) begin
        if (rd_exp.size() == 0) chk(1'b0, "R5", "unexpected rd_valid", rd_data, 0);
        else begin
          logic [7:0] e;
          e = rd_exp.pop_front();
          chk(rd_data == e, "R5", "payload byte", rd_data, e);
        end
      end
      if (rst_n && word_valid) begin
        if (word_exp.size() == 0) chk(1'b0, "R9", "unexpected word", word_data, 0);
        else begin
          logic [31:0] w;
          w = word_exp.pop_front();
          chk(word_data == w, "R9", "register word", word_data, w);
        end
      end
      if (rst_n && done) begin
        chk(status == exp_status, st_req, "status", status, exp_status);
        chk(busy == 1'b1, "R10", "busy during done", busy, 1);
        done_seen++;
      end
    end
  end

  task automatic pulse_start(input logic [1:0] m, input int n);
    @(negedge clk);
    start = 1'b1; mode = m; len = LEN_W'(n);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish_op(input int base);
    while (done_seen == base) @(negedge clk);
    @(negedge clk);
    #2;
    chk(busy == 1'b0, "R10", "busy after done", busy, 0);
    chk(tx_exp.size() == 0, tx_req, "bytes left unsent", tx_exp.size(), 0);
    chk(rd_exp.size() == 0, "R5", "payload bytes missing", rd_exp.size(), 0);
    chk(word_exp.size() == 0, "R9", "words missing", word_exp.size(), 0);
  endtask

  task automatic run_op(input logic [1:0] m, input int n, input logic [1:0] st,
                        input string treq, input string sreq);
    int base;
    exp_status = st; tx_req = treq; st_req = sreq;
    base = done_seen;
    pulse_start(m, n);
    finish_op(base);
  endtask

  task automatic fill_tx(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) tx_exp.push_back(b);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; mode = 2'b00; len = '0;
    repeat (3) @(negedge clk);
    #2;
    // R1 reset state
    chk(busy == 0 && done == 0, "R1", "busy/done in reset", {busy, done}, 0);
    chk(spi_go == 0 && wr_ready == 0, "R1", "go/ready in reset", {spi_go, wr_ready}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #2;
    chk(busy == 0 && rd_valid == 0 && word_valid == 0 && spi_go == 0, "R1",
        "outputs after reset", {busy, rd_valid, word_valid, spi_go}, 0);

    // R5 read of 4 bytes after two idle bytes
    rx_q = '{8'hFF, 8'hFF, 8'hFE, 8'h11, 8'h22, 8'h33, 8'h44, 8'hC1, 8'hC2};
    rd_exp = '{8'h11, 8'h22, 8'h33, 8'h44};
    fill_tx(8'hFF, 9);
    run_op(2'b00, 4, 2'b00, "R3", "R5");

    // R4 bad token
    rx_q = '{8'hFF, 8'h05};
    fill_tx(8'hFF, 2);
    run_op(2'b00, 4, 2'b10, "R4", "R4");

    // R3 token timeout after TOK tries
    fill_tx(8'hFF, TOK);
    run_op(2'b00, 4, 2'b01, "R3", "R3");

    // R3 token on the last try
    for (int i = 0; i < TOK - 1; i++) rx_q.push_back(8'hFF);
    rx_q.push_back(8'hFE); rx_q.push_back(8'h9A); rx_q.push_back(8'h00); rx_q.push_back(8'h00);
    rd_exp = '{8'h9A};
    fill_tx(8'hFF, TOK + 3);
    run_op(2'b00, 1, 2'b00, "R3", "R3");

    // R6 R7 R8 write of 3 bytes, accepted, busy then ready
    wr_pay = '{8'hA1, 8'hB2, 8'hC3}; wr_idx = 0;
    rx_q = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hE5, 8'h00, 8'h00, 8'hFF};
    tx_exp = '{8'hFE, 8'hA1, 8'hB2, 8'hC3, 8'h00, 8'h00, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
    run_op(2'b01, 3, 2'b00, "R6", "R8");
    chk(wr_idx == 3, "R6", "payload bytes taken", wr_idx, 3);

    // R7 rejected data response
    wr_pay = '{8'h5A}; wr_idx = 0;
    rx_q = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h0B};
    tx_exp = '{8'hFE, 8'h5A, 8'h00, 8'h00, 8'hFF};
    run_op(2'b01, 1, 2'b10, "R6", "R7");

    // R8 busy timeout
    wr_pay = '{8'h01}; wr_idx = 0;
    rx_q = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h05};
    rx_default = 8'h00;
    tx_exp = '{8'hFE, 8'h01, 8'h00, 8'h00, 8'hFF};
    fill_tx(8'hFF, BSY);
    run_op(2'b01, 1, 2'b01, "R8", "R8");
    rx_default = 8'hFF;

    // R9 register read, words reversed
    rx_q = '{8'hFF, 8'hFE};
    for (int i = 0; i < 16; i++) rx_q.push_back(8'(8'h10 + i));
    rx_q.push_back(8'h00); rx_q.push_back(8'h00);
    word_exp = '{32'h1C1D1E1F, 32'h18191A1B, 32'h14151617, 32'h10111213};
    fill_tx(8'hFF, 20);
    run_op(2'b10, 0, 2'b00, "R9", "R9");

    // R11 start while busy is ignored (a write would send 0xFE)
    begin
      int base;
      rx_q = '{8'hFF, 8'hFF, 8'hFF, 8'hFE, 8'hAA, 8'hBB, 8'h00, 8'h00};
      rd_exp = '{8'hAA, 8'hBB};
      fill_tx(8'hFF, 8);
      exp_status = 2'b00; tx_req = "R11"; st_req = "R11";
      base = done_seen;
      pulse_start(2'b00, 2);
      @(negedge clk);
      pulse_start(2'b01, 1);
      finish_op(base);
    end

    // R11 mode 11 start is ignored
    pulse_start(2'b11, 4);
    repeat (6) @(negedge clk);
    #2;
    chk(busy == 1'b0, "R11", "busy after mode 11 start", busy, 0);
    chk(done_seen == 9, "R11", "done count", done_seen, 9);

    // R12 full-length read
    rx_q.push_back(8'hFE);
    for (int i = 0; i < MAX_LEN; i++) begin
      rx_q.push_back(8'(i) ^ 8'h5A);
      rd_exp.push_back(8'(i) ^ 8'h5A);
    end
    rx_q.push_back(8'h00); rx_q.push_back(8'h00);
    fill_tx(8'hFF, MAX_LEN + 3);
    run_op(2'b00, MAX_LEN, 2'b00, "R12", "R12");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule